// File: doc/BRIEF.md
# Peripheral Soft-Reset and Clock-Gate Control Register

This block is the control word that a peripheral exposes on its register bus so that a bus master can put the peripheral into reset and wait for that reset to finish. The top bit of the word holds a soft-reset request and the bit below it holds a clock-gate flag. The remaining low bits are plain read/write storage. The register produces an internal reset and a clock enable, which the rest of the peripheral uses.

Writes come in three forms, selected by a 2-bit operation code. A normal write replaces the whole word. A set-alias write turns on only the bits that are 1 in the data. A clear-alias write turns off only the bits that are 1 in the data. While soft-reset is held and the clock is not yet gated, a settle timer counts peripheral clocks. When the count expires, the hardware sets the clock-gate bit. A master that polls the word therefore sees the clock-gate bit go to 1 once the reset has taken hold. The master then clears soft-reset and clock-gate to release the peripheral.

Top module: `srcg_ctrl_reg`

## Requirements
- R1: On synchronous reset the word reads 0xC000_0000, `periph_rst_o` is 1 and `periph_clk_en_o` is 0.
- R2: With `wr_op_i` = 2'b00 and `wr_en_i` high, the whole word takes `wr_data_i` at the clock edge, and `rd_data_o` shows the new value after that edge.
- R3: With `wr_op_i` = 2'b01 (set alias), each bit that is 1 in `wr_data_i` becomes 1. Every other bit keeps its value.
- R4: With `wr_op_i` = 2'b10 (clear alias), each bit that is 1 in `wr_data_i` becomes 0. Every other bit keeps its value.
- R5: A write with `wr_op_i` = 2'b11 has no effect on the stored word.
- R6: `periph_rst_o` equals bit 31 (soft-reset) of the word.
- R7: `periph_clk_en_o` is the inverse of bit 30 (clock-gate) of the word.
- R8: When bit 31 becomes 1 while bit 30 is 0, the hardware sets bit 30 exactly SETTLE_CYCLES clock edges later (3 by default). Bit 30 stays 0 before that edge.
- R9: If bit 30 is cleared while bit 31 is still 1, the settle timer starts again and bit 30 is set once more SETTLE_CYCLES edges later.
- R10: If bit 31 is cleared before the settle time expires, the timer is abandoned and bit 30 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_i | input | 1 | Synchronous active-high power-on reset |
| wr_en_i | input | 1 | Write strobe |
| wr_op_i | input | 2 | Write form: 00 normal, 01 set, 10 clear, 11 reserved |
| wr_data_i | input | 32 | Write data or bit mask |
| rd_data_o | output | 32 | Current control word |
| periph_rst_o | output | 1 | Internal reset to the peripheral |
| periph_clk_en_o | output | 1 | Clock enable to the peripheral |

## Verification
A wrong settle count shows up as the clock-gate bit rising one or more edges too early or too late after soft-reset is set. The bench samples every edge in that window, so such an error is caught within SETTLE_CYCLES + 1 clocks. A wrong write merge corrupts bits outside the written mask, which is visible on the read port after the very next edge. A timer that is not abandoned when soft-reset is dropped would later gate the clock of a released peripheral. The bench catches this by watching `periph_clk_en_o` for several cycles after the abort.

// File: rtl/srcg_pkg.sv
package srcg_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_SET   = 2'b01,
    OP_CLEAR = 2'b10,
    OP_RSVD  = 2'b11
  } wr_op_e;

endpackage

// File: rtl/srcg_wr_merge.sv
module srcg_wr_merge #(
  parameter int DATA_W = 32
) (
  input  logic              wr_en_i,
  input  logic [1:0]        wr_op_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] cur_i,
  output logic [DATA_W-1:0] nxt_o
);
  import srcg_pkg::*;

  wr_op_e op;
  assign op = wr_op_e'(wr_op_i);

  // per-bit merge cell
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_comb begin
      nxt_o[b] = cur_i[b];
      if (wr_en_i) begin
        case (op)
          OP_WRITE: nxt_o[b] = wr_data_i[b];
          OP_SET:   nxt_o[b] = cur_i[b] | wr_data_i[b];
          OP_CLEAR: nxt_o[b] = cur_i[b] & ~wr_data_i[b];
          default:  nxt_o[b] = cur_i[b];
        endcase
      end
    end
  end

endmodule

// File: rtl/srcg_settle_timer.sv
module srcg_settle_timer #(
  parameter int SETTLE_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sft_i,
  input  logic gate_i,
  output logic done_o
);
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed;

  assign armed  = sft_i & ~gate_i;
  assign done_o = armed & (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i || !armed || done_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= LAST); // R8
  AST_CNT_ABANDON: assert property (@(posedge clk_i) disable iff (rst_i)
    !sft_i |=> cnt_q == '0); // R10

endmodule

// File: rtl/srcg_ctrl_reg.sv
module srcg_ctrl_reg #(
  parameter int DATA_W        = 32,
  parameter int SFT_BIT       = 31,
  parameter int GATE_BIT      = 30,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_op_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              periph_rst_o,
  output logic              periph_clk_en_o
);
  localparam logic [DATA_W-1:0] SFT_MASK  = DATA_W'(1) << SFT_BIT;
  localparam logic [DATA_W-1:0] GATE_MASK = DATA_W'(1) << GATE_BIT;
  localparam logic [DATA_W-1:0] POR_VAL   = SFT_MASK | GATE_MASK;

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] sw_nxt;
  logic              hw_set;

  srcg_wr_merge #(.DATA_W(DATA_W)) u_merge (
    .wr_en_i   (wr_en_i),
    .wr_op_i   (wr_op_i),
    .wr_data_i (wr_data_i),
    .cur_i     (ctrl_q),
    .nxt_o     (sw_nxt)
  );

  srcg_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .sft_i  (ctrl_q[SFT_BIT]),
    .gate_i (ctrl_q[GATE_BIT]),
    .done_o (hw_set)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q <= POR_VAL;
    end else begin
      ctrl_q <= sw_nxt;
      if (hw_set) ctrl_q[GATE_BIT] <= 1'b1;
    end
  end

  assign rd_data_o       = ctrl_q;
  assign periph_rst_o    = ctrl_q[SFT_BIT];
  assign periph_clk_en_o = ~ctrl_q[GATE_BIT];

  AST_SET_ALIAS: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en_i && wr_op_i == 2'b01 |=> (ctrl_q & $past(wr_data_i)) == $past(wr_data_i)); // R3
  AST_CLEAR_ALIAS: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en_i && wr_op_i == 2'b10 |=> ((ctrl_q & $past(wr_data_i)) & ~GATE_MASK) == '0); // R4
  AST_RSVD_NO_CHANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en_i && wr_op_i == 2'b11 |=> (ctrl_q & ~GATE_MASK) == ($past(ctrl_q) & ~GATE_MASK)); // R5
  AST_HW_GATE_NEEDS_SFT: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ctrl_q[GATE_BIT]) && !$past(wr_en_i) |-> $past(ctrl_q[SFT_BIT])); // R8

endmodule

// File: tb/test_srcg_ctrl_reg.sv
module test_srcg_ctrl_reg;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_op = 2'b00;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        p_rst, p_clk_en;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;
  logic [31:0] exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  srcg_ctrl_reg #(.SETTLE_CYCLES(SETTLE)) i_srcg_ctrl_reg (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_op_i(wr_op),
    .wr_data_i(wr_data), .rd_data_o(rd_data),
    .periph_rst_o(p_rst), .periph_clk_en_o(p_clk_en)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic check_ports(string req, logic [31:0] expv);
    check(req, rd_data, expv);
    check({req, "/R6"}, {31'd0, p_rst}, {31'd0, expv[31]});
    check({req, "/R7"}, {31'd0, p_clk_en}, {31'd0, ~expv[30]});
  endtask

  // drive at negedge, return at next negedge (one edge later)
  task automatic wr(logic [1:0] op, logic [31:0] d);
    wr_en = 1'b1; wr_op = op; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_ports("R1", 32'hC000_0000);

    // R2 normal writes, walking ones over storage bits, sft/gate cleared
    for (int i = 0; i < 30; i++) begin
      exp = 32'd1 << i;
      wr(2'b00, exp);
      check("R2", rd_data, exp);
    end
    wr(2'b00, 32'h2AAA_5555);
    check_ports("R2", 32'h2AAA_5555);

    // R3 set alias accumulation
    wr(2'b00, 32'h0);
    exp = 32'h0;
    for (int i = 0; i < 30; i += 3) begin
      wr(2'b01, 32'h5 << i);
      exp = exp | (32'h5 << i);
      check("R3", rd_data, exp);
    end
    // R4 clear alias
    for (int i = 0; i < 30; i += 4) begin
      wr(2'b10, 32'h3 << i);
      exp = exp & ~(32'h3 << i);
      check("R4", rd_data, exp);
    end
    // R5 reserved op ignored
    wr(2'b11, 32'hFFFF_FFFF);
    check("R5", rd_data, exp);
    wr(2'b11, 32'h0);
    check("R5", rd_data, exp);

    // R8 settle timing from set of soft-reset
    wr(2'b00, 32'h0000_1234);
    wr(2'b01, 32'h8000_0000);           // edge E0
    check_ports("R8 E0", 32'h8000_1234);
    for (int k = 1; k < SETTLE; k++) begin
      idle(1);
      check_ports("R8 early", 32'h8000_1234);
    end
    idle(1);
    check_ports("R8 done", 32'hC000_1234);
    idle(2);
    check_ports("R8 hold", 32'hC000_1234);

    // R9 clear gate while soft-reset held: timer restarts
    wr(2'b10, 32'h4000_0000);
    check_ports("R9 E0", 32'h8000_1234);
    for (int k = 1; k < SETTLE; k++) begin
      idle(1);
      check_ports("R9 early", 32'h8000_1234);
    end
    idle(1);
    check_ports("R9 done", 32'hC000_1234);

    // release: clear both
    wr(2'b10, 32'hC000_0000);
    check_ports("R4 release", 32'h0000_1234);

    // R10 abort before completion
    wr(2'b01, 32'h8000_0000);
    wr(2'b10, 32'h8000_0000);
    check_ports("R10", 32'h0000_1234);
    for (int k = 0; k < 2 * SETTLE; k++) begin
      idle(1);
      check_ports("R10 hold", 32'h0000_1234);
    end

    // R1 reset again after activity
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    @(negedge clk);
    check_ports("R1 again", 32'hC000_0000);
    idle(2 * SETTLE);
    check_ports("R1 stays", 32'hC000_0000);

    finish_run();
  end

endmodule